// File: doc/BRIEF.md
# Ping-Pong Capture-to-Memory Halfword Buffer

This block sits between an image capture front end and a memory DMA port. A capture session opens with a one-cycle start pulse. From then on, each byte on the capture bus is taken whenever its ready strobe is high. Bytes are paired into 16-bit halfwords, with the earlier byte in bits 7:0 and the later byte in bits 15:8. The halfwords are written into one of two banks, each `DEPTH` halfwords deep. When a bank fills, it is handed to the memory side and writing carries on in the other bank. A one-cycle stop pulse closes the session. If a byte is left over, it is padded to a halfword with a zero high byte, and a partly filled bank is handed over with its exact halfword count.

The memory side raises a request for each bank that has been handed over, and drains the banks in the order they were filled. With the request it raises a sequential flag when the bank holds more than one halfword. Nothing moves until the acknowledge arrives. After that, the halfword on `mem_data` and its byte address on `mem_addr` advance by one on each memory-ready pulse. The address is loaded from `base_addr` when a start is accepted and steps by 2 for each halfword transferred. If a bank fills while the other bank is still waiting to be drained, `overflow` is set. Capture then stops taking bytes until the next accepted start.

The capture machine has the states CAP_IDLE, CAP_RUN and CAP_HALT:
- CAP_IDLE goes to CAP_RUN on an accepted start.
- CAP_RUN goes to CAP_IDLE on stop, which performs the flush.
- CAP_RUN goes to CAP_HALT when a bank fills while the other bank is still waiting (the overflow case).
- CAP_HALT goes to CAP_RUN on an accepted start, or to CAP_IDLE on stop.

The drain machine has the states DMA_IDLE, DMA_REQ and DMA_XFER:
- DMA_IDLE goes to DMA_REQ when the next bank in order is waiting.
- DMA_REQ goes to DMA_XFER on acknowledge.
- DMA_XFER goes back to DMA_IDLE on the ready pulse that moves the bank's last halfword.

Top module: `capture_dma_pingpong`

## Requirements
- R1: After reset, `dma_req`, `dma_seq` and `overflow` are all low.
- R2: Each halfword holds the earlier byte of its pair in bits 7:0 and the later byte in bits 15:8. Halfwords reach `mem_data` in arrival order.
- R3: Every byte that arrives with `cap_valid` high during a session is captured exactly once. This holds whether the strobe stays high on back-to-back clocks or drops for idle clocks between bytes.
- R4: When a bank receives its `DEPTH`-th halfword, that bank is handed to the memory side with count `DEPTH`, and `dma_req` rises. Later halfwords go to the other bank.
- R5: While `dma_req` is high, `dma_seq` is high exactly when the bank being served holds more than one halfword.
- R6: A `mem_rdy` pulse before `dma_ack` does not advance the data or the address.
- R7: After `dma_ack`, each `mem_rdy` pulse moves exactly one halfword. `dma_req` falls in the cycle after the pulse that moves the bank's last halfword.
- R8: On stop, an odd leftover byte becomes a halfword with high byte 0x00. A partly filled bank is handed over with its true count. If the current bank is empty, stop raises no request.
- R9: `mem_addr` takes `base_addr` when a start is accepted. It rises by 2 for each halfword transferred and runs on across banks.
- R10: If a bank fills while the other bank still waits, `overflow` goes high and stays high. Later bytes are dropped until a start is accepted, and that start clears `overflow`.
- R11: A start is ignored while a session is running or while any bank is waiting for transfer. Bytes that arrive outside a session are ignored.
- R12: Banks are drained in the same order in which they were handed over, alternating between the two banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_start | input | 1 | One-cycle pulse that opens a capture session |
| cap_stop | input | 1 | One-cycle pulse that closes a session and flushes any leftover data |
| cap_valid | input | 1 | Ready strobe for `cap_byte` |
| cap_byte | input | 8 | Captured byte |
| base_addr | input | ADDR_W | Memory byte address, loaded when a start is accepted |
| dma_req | output | 1 | A bank is waiting for transfer or is being transferred |
| dma_seq | output | 1 | The bank being served holds more than one halfword |
| dma_ack | input | 1 | Acknowledge that starts the transfer |
| mem_rdy | input | 1 | Memory-ready pulse; each one moves one halfword |
| mem_data | output | 16 | Halfword currently presented to memory |
| mem_addr | output | ADDR_W | Byte address of the presented halfword |
| overflow | output | 1 | Sticky flag: both banks were full at the same time |

## Verification
The bench uses four-halfword banks and sweeps session lengths from 1 to 15 bytes, varying the idle gap between strobes. This separates even from odd endings (zero padding), exact-fill from partial stops (counts and the sequential flag), and one-bank from two-bank sessions (drain order and address carry). A back-to-back stream of 24 bytes fills both banks and checks that overflow drops the third bank's bytes while the first two banks drain intact. Extra start pulses, sent while a session runs and while a bank waits, are checked through the drained addresses and data. Ready pulses sent before acknowledge are checked through the first halfword that is presented.

// File: rtl/capdma_pkg.sv
package capdma_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_RUN,
        CAP_HALT
    } cap_state_e;

    typedef enum logic [1:0] {
        DMA_IDLE,
        DMA_REQ,
        DMA_XFER
    } dma_state_e;
endpackage

// File: rtl/capture_ctrl.sv
module capture_ctrl
    import capdma_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_start,
    input  logic             cap_stop,
    input  logic             cap_valid,
    input  logic [7:0]       cap_byte,
    input  logic [1:0]       bank_busy,
    output logic             start_acc,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [IDX_W-1:0] wr_idx,
    output logic [15:0]      wr_data,
    output logic             hand_en,
    output logic             hand_bank,
    output logic [CNT_W-1:0] hand_cnt,
    output logic             overflow
);
    cap_state_e       state_q, state_d;
    logic [7:0]       low_q;
    logic             have_low_q;
    logic             bank_q;
    logic [IDX_W-1:0] idx_q;
    logic             ovf_q;

    logic             byte_in, pair_done, flush_pad, fill_last, stop_run;
    logic [CNT_W-1:0] stop_cnt;

    // Accepted start: not in a session and nothing waiting on the memory side.
    assign start_acc = cap_start && (state_q != CAP_RUN) && (bank_busy == 2'b00);

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (start_acc) state_d = CAP_RUN;
            CAP_RUN: begin
                if (cap_stop)
                    state_d = CAP_IDLE;
                else if (fill_last && bank_busy[~bank_q])
                    state_d = CAP_HALT;
            end
            CAP_HALT: begin
                if (start_acc)
                    state_d = CAP_RUN;
                else if (cap_stop)
                    state_d = CAP_IDLE;
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        stop_run  = (state_q == CAP_RUN) && cap_stop;
        byte_in   = (state_q == CAP_RUN) && !cap_stop && cap_valid;
        pair_done = byte_in && have_low_q;
        flush_pad = stop_run && have_low_q;
        fill_last = pair_done && (idx_q == IDX_W'(DEPTH - 1));
        stop_cnt  = CNT_W'(idx_q) + CNT_W'(flush_pad);
        wr_en     = pair_done || flush_pad;
        wr_data   = pair_done ? {cap_byte, low_q} : {8'h00, low_q};
        hand_en   = fill_last || (stop_run && (stop_cnt != '0));
        hand_cnt  = fill_last ? CNT_W'(DEPTH) : stop_cnt;
    end

    assign wr_bank   = bank_q;
    assign wr_idx    = idx_q;
    assign hand_bank = bank_q;
    assign overflow  = ovf_q;

    // Packing, index and bank pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q      <= '0;
            have_low_q <= 1'b0;
            bank_q     <= 1'b0;
            idx_q      <= '0;
            ovf_q      <= 1'b0;
        end else if (start_acc) begin
            have_low_q <= 1'b0;
            idx_q      <= '0;
            ovf_q      <= 1'b0;
        end else if (stop_run) begin
            have_low_q <= 1'b0;
            idx_q      <= '0;
            if (hand_en) bank_q <= ~bank_q;
        end else if (byte_in) begin
            if (!have_low_q) begin
                low_q      <= cap_byte;
                have_low_q <= 1'b1;
            end else begin
                have_low_q <= 1'b0;
                if (fill_last) begin
                    idx_q  <= '0;
                    bank_q <= ~bank_q;
                    if (bank_busy[~bank_q]) ovf_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    // R10: once raised, overflow holds until a start is accepted
    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !start_acc) |=> ovf_q);

    // R10: overflow only rises when both banks are waiting
    a_r10_overflow_both_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_q) |-> (bank_busy == 2'b11));

    // R11: a start seen while a bank waits leaves the capture state alone
    a_r11_start_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_start && !cap_stop && (bank_busy != 2'b00) && (state_q != CAP_RUN))
        |=> (state_q == $past(state_q)));
endmodule

// File: rtl/bank_store.sv
module bank_store #(
    parameter int DEPTH = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_bank,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [15:0]      wr_data,
    input  logic             rd_bank,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [15:0]      rd_data
);
    logic [15:0] rd_word [2];

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [15:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b)))
                mem[wr_idx] <= wr_data;
        end

        assign rd_word[b] = mem[rd_idx];
    end

    assign rd_data = rd_word[rd_bank];
endmodule

// File: rtl/dma_drain.sv
module dma_drain
    import capdma_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hand_en,
    input  logic              hand_bank,
    input  logic [CNT_W-1:0]  hand_cnt,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              dma_ack,
    input  logic              mem_rdy,
    output logic [1:0]        bank_busy,
    output logic              rd_bank,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              dma_req,
    output logic              dma_seq,
    output logic [ADDR_W-1:0] mem_addr
);
    dma_state_e        state_q, state_d;
    logic [1:0]        busy_q;
    logic [CNT_W-1:0]  cnt_q [2];
    logic              rd_bank_q;
    logic [IDX_W-1:0]  rd_idx_q;
    logic [ADDR_W-1:0] addr_q;

    logic [CNT_W-1:0]  cur_cnt;
    logic              last_hw, step, done;

    assign cur_cnt = cnt_q[rd_bank_q];
    assign last_hw = (CNT_W'(rd_idx_q) == (cur_cnt - CNT_W'(1)));

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DMA_IDLE: if (busy_q[rd_bank_q]) state_d = DMA_REQ;
            DMA_REQ:  if (dma_ack)           state_d = DMA_XFER;
            DMA_XFER: if (mem_rdy && last_hw) state_d = DMA_IDLE;
            default:  state_d = DMA_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DMA_IDLE;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        dma_req = (state_q != DMA_IDLE);
        dma_seq = (state_q != DMA_IDLE) && (cur_cnt > CNT_W'(1));
        step    = (state_q == DMA_XFER) && mem_rdy;
        done    = step && last_hw;
    end

    assign bank_busy = busy_q;
    assign rd_bank   = rd_bank_q;
    assign rd_idx    = rd_idx_q;
    assign mem_addr  = addr_q;

    // Bank status, read pointer and address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= '0;
            cnt_q[0]  <= '0;
            cnt_q[1]  <= '0;
            rd_bank_q <= 1'b0;
            rd_idx_q  <= '0;
            addr_q    <= '0;
        end else begin
            for (int b = 0; b < 2; b++) begin
                if (hand_en && (hand_bank == 1'(b))) begin
                    busy_q[b] <= 1'b1;
                    cnt_q[b]  <= hand_cnt;
                end else if (done && (rd_bank_q == 1'(b))) begin
                    busy_q[b] <= 1'b0;
                end
            end
            if ((state_q == DMA_REQ) && dma_ack)
                rd_idx_q <= '0;
            else if (step)
                rd_idx_q <= last_hw ? '0 : rd_idx_q + IDX_W'(1);
            if (done)
                rd_bank_q <= ~rd_bank_q;
            if (addr_load)
                addr_q <= base_addr;
            else if (step)
                addr_q <= addr_q + ADDR_W'(2);
        end
    end

    // R4: the capture side only hands over a bank that is free
    a_r4_handoff_free: assert property (@(posedge clk) disable iff (!rst_n)
        hand_en |-> !busy_q[hand_bank]);

    // R6: while waiting for acknowledge, the address does not move
    a_r6_hold_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == DMA_REQ) && !addr_load) |=> $stable(addr_q));

    // R9: each ready pulse during transfer advances the address by two
    a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == DMA_XFER) && mem_rdy && !addr_load)
        |=> (addr_q == $past(addr_q) + ADDR_W'(2)));

    // R7: the request stays up through a transfer that has not finished
    a_r7_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == DMA_XFER) && !mem_rdy) |=> dma_req);

    // R12: a finished bank hands the read pointer to the other bank
    a_r12_bank_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (rd_bank_q != $past(rd_bank_q)));
endmodule

// File: rtl/capture_dma_pingpong.sv
module capture_dma_pingpong #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_start,
    input  logic              cap_stop,
    input  logic              cap_valid,
    input  logic [7:0]        cap_byte,
    input  logic [ADDR_W-1:0] base_addr,
    output logic              dma_req,
    output logic              dma_seq,
    input  logic              dma_ack,
    input  logic              mem_rdy,
    output logic [15:0]       mem_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              overflow
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             start_acc;
    logic             wr_en, wr_bank;
    logic [IDX_W-1:0] wr_idx;
    logic [15:0]      wr_data;
    logic             hand_en, hand_bank;
    logic [CNT_W-1:0] hand_cnt;
    logic [1:0]       bank_busy;
    logic             rd_bank;
    logic [IDX_W-1:0] rd_idx;

    capture_ctrl #(.DEPTH(DEPTH)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_start (cap_start),
        .cap_stop  (cap_stop),
        .cap_valid (cap_valid),
        .cap_byte  (cap_byte),
        .bank_busy (bank_busy),
        .start_acc (start_acc),
        .wr_en     (wr_en),
        .wr_bank   (wr_bank),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .hand_en   (hand_en),
        .hand_bank (hand_bank),
        .hand_cnt  (hand_cnt),
        .overflow  (overflow)
    );

    bank_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_bank (rd_bank),
        .rd_idx  (rd_idx),
        .rd_data (mem_data)
    );

    dma_drain #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .hand_en   (hand_en),
        .hand_bank (hand_bank),
        .hand_cnt  (hand_cnt),
        .addr_load (start_acc),
        .base_addr (base_addr),
        .dma_ack   (dma_ack),
        .mem_rdy   (mem_rdy),
        .bank_busy (bank_busy),
        .rd_bank   (rd_bank),
        .rd_idx    (rd_idx),
        .dma_req   (dma_req),
        .dma_seq   (dma_seq),
        .mem_addr  (mem_addr)
    );
endmodule

// File: tb/test_capture_dma_pingpong.sv
module test_capture_dma_pingpong;
    localparam int DEPTH  = 4;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cap_start, cap_stop, cap_valid;
    logic [7:0]        cap_byte;
    logic [ADDR_W-1:0] base_addr;
    logic              dma_req, dma_seq, dma_ack, mem_rdy;
    logic [15:0]       mem_data;
    logic [ADDR_W-1:0] mem_addr;
    logic              overflow;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    capture_dma_pingpong #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_capture_dma_pingpong (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_start (cap_start),
        .cap_stop  (cap_stop),
        .cap_valid (cap_valid),
        .cap_byte  (cap_byte),
        .base_addr (base_addr),
        .dma_req   (dma_req),
        .dma_seq   (dma_seq),
        .dma_ack   (dma_ack),
        .mem_rdy   (mem_rdy),
        .mem_data  (mem_data),
        .mem_addr  (mem_addr),
        .overflow  (overflow)
    );

    function automatic logic [7:0] bval(int k, int seed);
        return 8'(k * 37 + seed * 11 + 5);
    endfunction

    // Expected halfword j of an n-byte session (R2, R8)
    function automatic logic [15:0] hw(int j, int n, int seed);
        logic [7:0] lo, hi;
        lo = bval(2 * j, seed);
        hi = (2 * j + 1 < n) ? bval(2 * j + 1, seed) : 8'h00;
        return {hi, lo};
    endfunction

    task automatic check(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_pulse(int base);
        cap_start = 1'b1;
        base_addr = ADDR_W'(base);
        @(negedge clk);
        cap_start = 1'b0;
    endtask

    task automatic stop_pulse();
        cap_stop = 1'b1;
        @(negedge clk);
        cap_stop = 1'b0;
    endtask

    task automatic send(int n, int gap, int seed);
        for (int k = 0; k < n; k++) begin
            cap_valid = 1'b1;
            cap_byte  = bval(k, seed);
            @(negedge clk);
            if (gap > 0) begin
                cap_valid = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        cap_valid = 1'b0;
    endtask

    task automatic drain(int cnt, int first, int n, int seed, int base);
        int t = 0;
        while (!dma_req && t < 40) begin
            @(negedge clk);
            t++;
        end
        check("R4 request raised", int'(dma_req), 1);
        check("R5 sequential flag", int'(dma_seq), (cnt > 1) ? 1 : 0);
        // R6: ready before acknowledge must not advance anything
        mem_rdy = 1'b1;
        @(negedge clk);
        mem_rdy = 1'b0;
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            check("R2 R3 R6 halfword data", int'(mem_data), int'(hw(first + i, n, seed)));
            check("R9 address", int'(mem_addr), (base + 2 * (first + i)) & 16'hFFFF);
            mem_rdy = 1'b1;
            @(negedge clk);
            mem_rdy = 1'b0;
        end
        check("R7 request dropped after count", int'(dma_req), 0);
    endtask

    task automatic quiet(int cycles, string req);
        int seen = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (dma_req) seen = 1;
        end
        check(req, seen, 0);
    endtask

    initial begin
        #2_000_000;
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cap_start = 1'b0;
        cap_stop  = 1'b0;
        cap_valid = 1'b0;
        cap_byte  = '0;
        base_addr = '0;
        dma_ack   = 1'b0;
        mem_rdy   = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset request", int'(dma_req), 0);
        check("R1 reset sequential", int'(dma_seq), 0);
        check("R1 reset overflow", int'(overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R4: back-to-back strobes fill exactly one bank
        start_pulse(16'h0100);
        send(2 * DEPTH, 0, 1);
        drain(DEPTH, 0, 2 * DEPTH, 1, 16'h0100);
        stop_pulse();
        quiet(10, "R8 empty bank on stop raises no request");

        // R3 R8 R12: sweep of session lengths and strobe gaps
        for (int len = 1; len < 4 * DEPTH; len++) begin
            int h;
            h = (len + 1) / 2;
            start_pulse(len * 16'h40);
            send(len, len % 4, len);
            stop_pulse();
            drain((h > DEPTH) ? DEPTH : h, 0, len, len, len * 16'h40);
            if (h > DEPTH)
                drain(h - DEPTH, DEPTH, len, len, len * 16'h40);
            quiet(3, "R12 no extra request after session");
        end

        // R10: both banks full raises overflow, extra bytes dropped
        start_pulse(16'h0800);
        send(6 * DEPTH, 0, 7);
        check("R10 overflow raised", int'(overflow), 1);
        drain(DEPTH, 0, 6 * DEPTH, 7, 16'h0800);
        drain(DEPTH, DEPTH, 6 * DEPTH, 7, 16'h0800);
        stop_pulse();
        quiet(10, "R10 dropped bytes not transferred");
        check("R10 overflow sticky", int'(overflow), 1);
        start_pulse(16'h0900);
        check("R10 start clears overflow", int'(overflow), 0);
        send(2, 1, 3);
        stop_pulse();
        drain(1, 0, 2, 3, 16'h0900);

        // R11: start while a bank waits, and bytes outside a session
        start_pulse(16'h0A00);
        send(3, 0, 4);
        stop_pulse();
        start_pulse(16'h0C00);
        send(4, 0, 9);
        drain(2, 0, 3, 4, 16'h0A00);
        quiet(10, "R11 bytes outside session ignored");

        // R11: start during a running session is ignored
        start_pulse(16'h0D00);
        send(4, 0, 6);
        start_pulse(16'h0E00);
        stop_pulse();
        drain(2, 0, 4, 6, 16'h0D00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule